// File: doc/BRIEF.md
# Cache Access Classifier with Three-Way Miss Breakdown

This block models a small set-associative cache and labels every access it sees. Each strobed 32-bit byte address is looked up in a 2-way tag store of 4 sets with one-word blocks. The block reports whether the access hit. A miss is given one of three causes: the block was never touched before (compulsory), the cache was too small for the working set (capacity), or two blocks fought over the same set (conflict). Only tags, valid bits and recency state are kept. No data is stored.

The cause of a miss is worked out from two pieces of shadow state. The first is a record of every distinct block address seen since reset. Its depth is a parameter, and a sticky flag rises when a new block no longer fits. The second is a fully associative LRU cache with the same total block count as the real cache, fed with the same access stream. A repeat miss that this shadow would have caught is blamed on set mapping (conflict). One that the shadow also misses is blamed on size (capacity).

The result appears one clock after the strobe as a registered kind code with a valid pulse. All state updates at the edge that samples the strobe, so accesses may arrive on every cycle.

Top module: `miss_classifier`

## Requirements
- R1: The block address is address bits [31:2], the set index is bits [3:2] and the tag is bits [31:4]; bits [1:0] do not affect the result.
- R2: `res_valid` is high in the cycle after each cycle with `acc_valid` high and low in the cycle after each cycle with `acc_valid` low.
- R3: An access whose tag matches a valid way of its set is reported with kind code 0 (hit).
- R4: Within a set, a fill uses an empty way first (way 0 before way 1), otherwise the least recently used way; both hits and fills mark the way just used as most recent.
- R5: A miss on a block address not accessed since reset is reported with kind code 1 (compulsory).
- R6: A miss on a previously accessed block is reported with kind code 2 (conflict) if an 8-entry fully associative LRU cache fed the same stream would hit, and with code 3 (capacity) if it would also miss.
- R7: When a new block address arrives while the history already holds HIST_DEPTH distinct blocks, `hist_overflow` rises and stays high until reset; such a block is not recorded and still reads as compulsory.
- R8: A synchronous active-high reset empties the tag store, the shadow cache and the history, clears `hist_overflow` and drops `res_valid`.
- R9: Every valid result carries exactly one of the four kind codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe; the address is sampled when high |
| acc_addr | input | 32 | Byte address of the access |
| res_valid | output | 1 | High for one cycle, one cycle after each strobe |
| res_kind | output | 2 | 0 hit, 1 compulsory, 2 conflict, 3 capacity |
| hist_overflow | output | 1 | Sticky flag: the seen-block history ran out of room |

## Verification
The assertions assume that the strobe and the address are clean at each rising edge. They also assume that a block reaching the main cache as a hit was recorded in the history unless the overflow flag is set, which holds only because all three structures see the same strobe. The bench drives all inputs on falling edges and keeps the strobe to one cycle per access. It also starts every directed scenario from a fresh reset, so the history never overflows except in the one test aimed at R7. Expected kinds come from a hand-worked trace of the tag store, the recency order of the shadow and the history. That trace includes evictions in the shadow, which is what turns a repeat miss into a capacity miss.

// File: rtl/mcls_pkg.sv
package mcls_pkg;

    localparam int ADDR_W = 32;
    localparam int OFS_W  = 2;
    localparam int BLK_W  = ADDR_W - OFS_W;

    typedef enum logic [1:0] {
        KIND_HIT      = 2'd0,
        KIND_COLD     = 2'd1,
        KIND_CONFLICT = 2'd2,
        KIND_CAPACITY = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic main_hit;
        logic seen;
        logic shadow_hit;
    } probe_t;

    function automatic acc_kind_e classify(input probe_t p);
        if (p.main_hit)        return KIND_HIT;
        else if (!p.seen)      return KIND_COLD;
        else if (p.shadow_hit) return KIND_CONFLICT;
        else                   return KIND_CAPACITY;
    endfunction

endpackage

// File: rtl/set_tag_store.sv
module set_tag_store #(
    parameter int IDX_W = 2,
    parameter int TAG_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    output logic             hit
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS][2];
    logic [1:0]       vld_q [SETS];
    logic [SETS-1:0]  lru_q;

    logic hit0, hit1, victim, used_way;

    always_comb begin
        hit0 = vld_q[idx][0] && (tag_q[idx][0] == tag);
        hit1 = vld_q[idx][1] && (tag_q[idx][1] == tag);
        hit  = hit0 || hit1;
        if (!vld_q[idx][0])      victim = 1'b0;
        else if (!vld_q[idx][1]) victim = 1'b1;
        else                     victim = lru_q[idx];
        used_way = hit ? hit1 : victim;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= 2'b00;
            lru_q <= '0;
        end else if (upd) begin
            lru_q[idx] <= ~used_way;
            if (!hit) vld_q[idx][victim] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && upd && !hit) tag_q[idx][victim] <= tag;
    end

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set_chk
            // R4: a set never holds the same block in both ways
            a_r4_ways_distinct: assert property (@(posedge clk) disable iff (rst)
                (vld_q[s] == 2'b11) |-> (tag_q[s][0] != tag_q[s][1]));
        end
    endgenerate

    // R4: a fill into a full set replaces the way the LRU bit named
    a_r4_lru_victim: assert property (@(posedge clk) disable iff (rst)
        (upd && !hit && vld_q[idx] == 2'b11) |=> (lru_q[$past(idx)] != $past(lru_q[idx])));

endmodule

// File: rtl/fa_shadow.sv
module fa_shadow #(
    parameter int N     = 8,
    parameter int KEY_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [KEY_W-1:0] key,
    output logic             hit
);
    localparam int AGE_W = $clog2(N);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(N - 1);

    logic [KEY_W-1:0] key_q [N];
    logic [AGE_W-1:0] age_q [N];
    logic [N-1:0]     vld_q;
    logic [N-1:0]     match, oldest;
    logic [AGE_W-1:0] ref_age;

    always_comb begin
        ref_age = OLDEST;
        for (int i = 0; i < N; i++) begin
            match[i]  = vld_q[i] && (key_q[i] == key);
            oldest[i] = (age_q[i] == OLDEST);
            if (match[i]) ref_age = age_q[i];
        end
        hit = |match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < N; i++) age_q[i] <= AGE_W'(i);
        end else if (upd) begin
            for (int i = 0; i < N; i++) begin
                if (hit ? match[i] : oldest[i]) begin
                    age_q[i] <= '0;
                    if (!hit) vld_q[i] <= 1'b1;
                end else if (age_q[i] < ref_age) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++)
            if (!rst && upd && !hit && oldest[i]) key_q[i] <= key;
    end

    // R6: the recency ages stay a permutation, so exactly one entry is oldest
    a_r6_one_oldest: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest) == 1);

    // R6: a key is never held twice
    a_r6_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/seen_history.sv
module seen_history #(
    parameter int DEPTH = 32,
    parameter int KEY_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [KEY_W-1:0] key,
    output logic             seen,
    output logic             overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [KEY_W-1:0] key_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full;

    always_comb begin
        seen = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (vld_q[i] && key_q[i] == key) seen = 1'b1;
        full = (cnt_q == CNT_W'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= '0;
            cnt_q    <= '0;
            overflow <= 1'b0;
        end else if (upd && !seen) begin
            if (full) begin
                overflow <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                for (int i = 0; i < DEPTH; i++)
                    if (cnt_q == CNT_W'(i)) vld_q[i] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++)
            if (!rst && upd && !seen && cnt_q == CNT_W'(i)) key_q[i] <= key;
    end

    // R7: once raised, the overflow flag holds until reset
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R7: the flag rises only on a new block arriving at a full history
    a_r7_overflow_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(upd && !seen && full));

endmodule

// File: rtl/miss_classifier.sv
module miss_classifier #(
    parameter int IDX_W      = 2,
    parameter int SHADOW_N   = 8,
    parameter int HIST_DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic [31:0] acc_addr,
    output logic        res_valid,
    output logic [1:0]  res_kind,
    output logic        hist_overflow
);
    import mcls_pkg::*;

    localparam int TAG_W = ADDR_W - OFS_W - IDX_W;

    logic [BLK_W-1:0] blk;
    logic [IDX_W-1:0] set_idx;
    logic [TAG_W-1:0] tag;
    probe_t           probe;
    acc_kind_e        kind_d;

    assign blk     = acc_addr[ADDR_W-1:OFS_W];
    assign set_idx = acc_addr[OFS_W+IDX_W-1:OFS_W];
    assign tag     = acc_addr[ADDR_W-1:OFS_W+IDX_W];

    set_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .upd(acc_valid),
        .idx(set_idx), .tag(tag), .hit(probe.main_hit)
    );

    fa_shadow #(.N(SHADOW_N), .KEY_W(BLK_W)) u_shadow (
        .clk(clk), .rst(rst), .upd(acc_valid),
        .key(blk), .hit(probe.shadow_hit)
    );

    seen_history #(.DEPTH(HIST_DEPTH), .KEY_W(BLK_W)) u_hist (
        .clk(clk), .rst(rst), .upd(acc_valid),
        .key(blk), .seen(probe.seen), .overflow(hist_overflow)
    );

    assign kind_d = classify(probe);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_kind  <= KIND_HIT;
        end else begin
            res_valid <= acc_valid;
            if (acc_valid) res_kind <= kind_d;
        end
    end

    // R2: one result per strobe, exactly one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !res_valid);

    // R5: anything resident in the cache was recorded as seen
    a_r5_hit_was_seen: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && probe.main_hit && !hist_overflow) |-> probe.seen);

    // R9: the reported kind stays put between results
    a_r9_kind_stable: assert property (@(posedge clk) disable iff (rst)
        !$past(acc_valid) |-> $stable(res_kind));

endmodule

// File: tb/sim_miss_classifier.sv
module sim_miss_classifier;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic        hist_overflow;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    miss_classifier u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .res_valid(res_valid), .res_kind(res_kind), .hist_overflow(hist_overflow)
    );

    // kind codes: 0 hit, 1 compulsory, 2 conflict, 3 capacity
    localparam int NV = 20;
    localparam logic [31:0] VEC_ADDR [NV] = '{
        32'd4, 32'd0, 32'd32, 32'd16, 32'd8, 32'd20, 32'd40, 32'd8, 32'd12, 32'd100,
        32'd0, 32'd36, 32'd68, 32'd4, 32'd16, 32'd40, 32'd8, 32'd20, 32'd36, 32'd4 };
    localparam logic [1:0] VEC_KIND [NV] = '{
        2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd0, 2'd1, 2'd1,
        2'd2, 2'd1, 2'd1, 2'd3, 2'd0, 2'd0, 2'd0, 2'd3, 2'd2, 2'd2 };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // strobe on one falling edge, check the result on the next
    task automatic access(input logic [31:0] addr, input logic [1:0] exp, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = addr;
        @(negedge clk);
        acc_valid = 1'b0;
        check({req, " valid"}, {31'd0, res_valid}, 32'd1);
        check(req, {30'd0, res_kind}, {30'd0, exp});
    endtask

    initial begin
        do_reset();
        // R8: reset state
        check("R8 res_valid after reset", {31'd0, res_valid}, 32'd0);
        check("R8 overflow after reset", {31'd0, hist_overflow}, 32'd0);

        // R1 R3 R5 R6 R9: classic trace with conflicts, capacity and hits
        for (int i = 0; i < NV; i++)
            access(VEC_ADDR[i], VEC_KIND[i], $sformatf("R6 trace step %0d", i));

        // R2: no result without a strobe
        @(negedge clk);
        check("R2 idle res_valid", {31'd0, res_valid}, 32'd0);

        // R8: reset empties everything; a resident block becomes compulsory again
        do_reset();
        access(32'd8, 2'd1, "R8 cold after reset");
        access(32'd8, 2'd0, "R3 repeat hits");
        // R1: byte offset bits do not matter
        access(32'd11, 2'd0, "R1 offset ignored");
        // R1: same set and same low tag bits, different high tag -> miss
        access(32'h8000_0008, 2'd1, "R1 high tag bits used");

        // R4: LRU updated on hit
        do_reset();
        access(32'd0,  2'd1, "R4 fill way0");
        access(32'd16, 2'd1, "R4 fill way1");
        access(32'd0,  2'd0, "R4 hit refreshes blk0");
        access(32'd32, 2'd1, "R4 evicts blk4");
        access(32'd0,  2'd0, "R4 blk0 kept");
        access(32'd16, 2'd2, "R4 blk4 evicted, conflict");

        // R7: history overflow with default depth 32
        do_reset();
        for (int k = 0; k < 32; k++) access(32'(k * 4), 2'd1, "R7 fill history");
        check("R7 no overflow at depth", {31'd0, hist_overflow}, 32'd0);
        access(32'd128, 2'd1, "R7 new block beyond depth");
        check("R7 overflow raised", {31'd0, hist_overflow}, 32'd1);
        access(32'd0, 2'd3, "R7 recorded block still known, capacity");
        // blk32 was not recorded; evict it from set0 and return: still compulsory
        access(32'd144, 2'd1, "R7 blk36 new");
        access(32'd160, 2'd1, "R7 blk40 new");
        access(32'd128, 2'd1, "R7 unrecorded block reads compulsory");
        check("R7 overflow sticky", {31'd0, hist_overflow}, 32'd1);

        do_reset();
        check("R8 overflow cleared", {31'd0, hist_overflow}, 32'd0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule